// File: doc/BRIEF.md
# Two-Phase Interval Timer Pair with Watchdog Option

This peripheral holds two independent down-counting timers behind a small register bus. Each timer's period has two stages: a first stage whose length comes from a "lead" count register, then a second stage whose length comes from a "tail" count register. The event interval is the sum of the two. At the end of the tail stage the timer emits a one-cycle interrupt pulse, reloads both stages from the registers and runs again, for as long as its enable bit stays set.

Timer 0 can serve as a watchdog instead. When the low byte of its lead register holds 0xFF, the upper bits of that register give a single countdown. When that countdown expires, a reset request is raised and held until the next synchronous reset. To reprogram a timer, software clears its enable bit, rewrites the counts and sets the bit again. Setting the bit always starts a fresh period from the stored values.

Top module: `dual_phase_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads 0 and irq and wdog_rst_req are 0.
- R2: Registers sit at these byte offsets: control at 0x00, timer 1 lead count at 0x04, timer 0 lead count at 0x08, timer 1 tail count at 0x0C and timer 0 tail count at 0x10. Each reads back its last written value (control reads its 2 bits, zero-extended). A read of any other offset returns 0, and a write there changes no register.
- R3: Control bit 0 enables timer 0 and bit 1 enables timer 1. Each bit affects only its own timer, and irq[n] belongs to timer n.
- R4: A control write that sets an enable bit at clock edge W starts that timer. irq[n] is then high for exactly one cycle after edge W+L+T, where L is the lead count and T the tail count. The pulse repeats every L+T cycles while the timer stays enabled.
- R5: A lead or tail count of 0 lasts one cycle, so the shortest period is 2 cycles.
- R6: A control write that clears an enable bit stops that timer at that edge, with no interrupt or reset request. Setting the bit again starts a full period from the programmed counts.
- R7: When timer 0's lead register has 0xFF in bits 7:0, timer 0 is a watchdog with count C = bits 31:8. Enabling it at edge W raises wdog_rst_req after edge W+max(C,1), and irq[0] stays 0 in this mode.
- R8: Once wdog_rst_req is 1, it stays 1, even if the timer is disabled, until a synchronous reset.
- R9: Timer 1 has no watchdog mode. A lead count with 0xFF in its low byte is an ordinary count, and wdog_rst_req never rises from timer 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 2 | One-cycle interrupt pulse per timer |
| wdog_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The bench measures the cycle distance from the enabling write to each interrupt and between successive interrupts. A design that counted a phase one cycle short or long, or that skipped one phase, would show the wrong distance. Zero counts are programmed to catch a timer that wraps to a huge count or never fires. A timer is disabled in mid-period and then re-enabled; a design that resumed from the old count, or let a pending interrupt slip out, shows up as an early pulse or a stray one. Watchdog tests check the expiry cycle, a silent irq[0], a request that survives the enable bit being cleared, and timer 1 ignoring the 0xFF selector.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int NUM_TMR = 2;
    localparam int WD_SEL_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_T1_LEAD = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_T0_LEAD = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_T1_TAIL = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_T0_TAIL = 5'h10;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_LEAD = 2'd1,
        CH_TAIL = 2'd2,
        CH_HALT = 2'd3
    } ch_state_e;

    typedef struct packed {
        logic [NUM_TMR-1:0] ctrl;
        logic [DATA_W-1:0]  lead0;
        logic [DATA_W-1:0]  tail0;
        logic [DATA_W-1:0]  lead1;
        logic [DATA_W-1:0]  tail1;
    } regs_t;
endpackage

// File: rtl/dpt_regfile.sv
module dpt_regfile
    import dpt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_TMR-1:0]  en_next_o,
    output logic [DATA_W-1:0]   lead_o [NUM_TMR],
    output logic [DATA_W-1:0]   tail_o [NUM_TMR]
);
    regs_t regs_d, regs_q;
    logic  hit;

    // Decode and next-state computation for the register file
    always_comb begin
        regs_d = regs_q;
        hit    = 1'b1;
        unique case (bus_addr)
            OFS_CTRL, OFS_T1_LEAD, OFS_T0_LEAD,
            OFS_T1_TAIL, OFS_T0_TAIL: hit = 1'b1;
            default:                  hit = 1'b0;
        endcase
        if (bus_sel && bus_we) begin
            case (bus_addr)
                OFS_CTRL:    regs_d.ctrl  = bus_wdata[NUM_TMR-1:0];
                OFS_T1_LEAD: regs_d.lead1 = bus_wdata;
                OFS_T0_LEAD: regs_d.lead0 = bus_wdata;
                OFS_T1_TAIL: regs_d.tail1 = bus_wdata;
                OFS_T0_TAIL: regs_d.tail0 = bus_wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // Read mux: unmapped offsets give zero
    always_comb begin
        case (bus_addr)
            OFS_CTRL:    bus_rdata = {{(DATA_W-NUM_TMR){1'b0}}, regs_q.ctrl};
            OFS_T1_LEAD: bus_rdata = regs_q.lead1;
            OFS_T0_LEAD: bus_rdata = regs_q.lead0;
            OFS_T1_TAIL: bus_rdata = regs_q.tail1;
            OFS_T0_TAIL: bus_rdata = regs_q.tail0;
            default:     bus_rdata = '0;
        endcase
    end

    // Timers act on the enable value being written, so a disable takes effect at its edge
    assign en_next_o = regs_d.ctrl;
    assign lead_o[0] = regs_q.lead0;
    assign tail_o[0] = regs_q.tail0;
    assign lead_o[1] = regs_q.lead1;
    assign tail_o[1] = regs_q.tail1;

    // R2: a write to an unmapped offset leaves every register as it was
    p_unmapped_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !hit) |=> $stable(regs_q));

    // R2: a mapped read of control shows only the enable bits
    p_ctrl_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) |-> (bus_rdata[DATA_W-1:NUM_TMR] == '0));
endmodule

// File: rtl/dpt_channel.sv
module dpt_channel
    import dpt_pkg::*;
#(
    parameter int CNT_W       = DATA_W,
    parameter bit WD_CAPABLE  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] lead_i,
    input  logic [CNT_W-1:0] tail_i,
    output logic             irq_o,
    output logic             rst_req_o
);
    localparam logic [WD_SEL_W-1:0] WD_MAGIC = '1;
    localparam logic [CNT_W-1:0]    ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        ch_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rst_req;
    } ch_t;

    ch_t q, d;
    logic             wd_mode;
    logic [CNT_W-1:0] wd_count;

    // Remaining-cycle load value: a count of 0 behaves as 1
    function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : (n - ONE);
    endfunction

    generate
        if (WD_CAPABLE) begin : g_wd
            assign wd_mode  = (lead_i[WD_SEL_W-1:0] == WD_MAGIC);
            assign wd_count = {{WD_SEL_W{1'b0}}, lead_i[CNT_W-1:WD_SEL_W]};
        end else begin : g_plain
            assign wd_mode  = 1'b0;
            assign wd_count = '0;
        end
    endgenerate

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (!en_i) begin
            d.state = CH_IDLE;
            d.cnt   = '0;
        end else begin
            unique case (q.state)
                CH_IDLE: begin
                    d.state = CH_LEAD;
                    d.cnt   = wd_mode ? load_of(wd_count) : load_of(lead_i);
                end
                CH_LEAD: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - ONE;
                    end else if (wd_mode) begin
                        d.state   = CH_HALT;
                        d.rst_req = 1'b1;
                    end else begin
                        d.state = CH_TAIL;
                        d.cnt   = load_of(tail_i);
                    end
                end
                CH_TAIL: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - ONE;
                    end else begin
                        d.irq   = 1'b1;
                        d.state = CH_LEAD;
                        d.cnt   = load_of(lead_i);
                    end
                end
                default: d.state = CH_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: CH_IDLE, cnt: '0, irq: 1'b0, rst_req: 1'b0};
        else        q <= d;
    end

    assign irq_o     = q.irq;
    assign rst_req_o = q.rst_req;

    // R4: the interrupt is a single-cycle pulse
    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |=> !q.irq);

    // R6: a cleared enable leaves the timer idle and silent
    p_stop_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!q.irq && q.state == CH_IDLE));

    // R7: a watchdog countdown never raises the interrupt
    p_wd_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wd_mode && q.state == CH_LEAD) |=> !q.irq);

    // R8: the reset request holds until reset
    p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.rst_req |=> q.rst_req);

    generate
        if (!WD_CAPABLE) begin : g_chk_plain
            // R9: the magic byte does nothing on a timer without watchdog mode
            p_no_wd_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (lead_i[WD_SEL_W-1:0] == WD_MAGIC) |=> !q.rst_req);
        end
    endgenerate
endmodule

// File: rtl/dual_phase_timer.sv
module dual_phase_timer
    import dpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_TMR-1:0] irq,
    output logic               wdog_rst_req
);
    logic [NUM_TMR-1:0] en_next;
    logic [DATA_W-1:0]  lead [NUM_TMR];
    logic [DATA_W-1:0]  tail [NUM_TMR];
    logic [NUM_TMR-1:0] rst_req;

    dpt_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_next_o (en_next),
        .lead_o    (lead),
        .tail_o    (tail)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        dpt_channel #(
            .CNT_W      (DATA_W),
            .WD_CAPABLE (g == 0)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (en_next[g]),
            .lead_i    (lead[g]),
            .tail_i    (tail[g]),
            .irq_o     (irq[g]),
            .rst_req_o (rst_req[g])
        );
    end

    assign wdog_rst_req = |rst_req;

    // R3: a timer whose enable is clear produces no interrupt
    p_irq_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_next == '0) |=> (irq == '0));
endmodule

// File: tb/dual_phase_timer_tb.sv
module dual_phase_timer_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    logic        wdog_rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_phase_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq          (irq),
        .wdog_rst_req (wdog_rst_req)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write lands at the next rising edge; returns at the falling edge after it
    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic bit sig(input int which);
        if (which == 2) return wdog_rst_req;
        return irq[which];
    endfunction

    // Count falling edges until the chosen signal is high
    task automatic wait_sig(input int which, input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sig(which) && n < limit);
        if (!sig(which)) n = -1;
    endtask

    task automatic count_high(input int which, input int cycles, output int hits);
        hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sig(which)) hits++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < 5; i++) begin
            rd(5'(i*4), v);
            check(v == 0, "R1 reg after reset", v, 0);
        end
        check(irq == 0 && wdog_rst_req == 0, "R1 outputs after reset", {irq, wdog_rst_req}, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(5'h04, 32'h1111_0004);
        wr(5'h08, 32'h2222_0008);
        wr(5'h0C, 32'h3333_000C);
        wr(5'h10, 32'h4444_0010);
        wr(5'h14, 32'hDEAD_BEEF);
        wr(5'h02, 32'hDEAD_BEEF);
        rd(5'h04, v); check(v == 32'h1111_0004, "R2 t1 lead", v, 32'h1111_0004);
        rd(5'h08, v); check(v == 32'h2222_0008, "R2 t0 lead", v, 32'h2222_0008);
        rd(5'h0C, v); check(v == 32'h3333_000C, "R2 t1 tail", v, 32'h3333_000C);
        rd(5'h10, v); check(v == 32'h4444_0010, "R2 t0 tail", v, 32'h4444_0010);
        rd(5'h14, v); check(v == 0, "R2 unmapped read", v, 0);
        rd(5'h00, v); check(v == 0, "R2 control untouched by unmapped write", v, 0);
        check(irq == 0, "R2 no timer started by unmapped write", irq, 0);
    endtask

    task automatic t_period();
        int n;
        wr(5'h08, 3); wr(5'h10, 5);
        wr(5'h00, 1);
        wait_sig(0, 100, n); check(n == 8, "R4 first irq0 at lead+tail", n, 8);
        wait_sig(0, 100, n); check(n == 8, "R4 irq0 repeat period", n, 8);
        wr(5'h00, 0);
        wr(5'h08, 1); wr(5'h10, 1);
        wr(5'h00, 1);
        wait_sig(0, 100, n); check(n == 2, "R4 1+1 first", n, 2);
        wait_sig(0, 100, n); check(n == 2, "R4 1+1 repeat", n, 2);
        wr(5'h00, 0);
    endtask

    task automatic t_zero();
        int n;
        wr(5'h08, 0); wr(5'h10, 0);
        wr(5'h00, 1);
        wait_sig(0, 100, n); check(n == 2, "R5 zero counts give 2", n, 2);
        wait_sig(0, 100, n); check(n == 2, "R5 zero counts repeat", n, 2);
        wr(5'h00, 0);
        wr(5'h10, 4);
        wr(5'h00, 1);
        wait_sig(0, 100, n); check(n == 5, "R5 lead 0 tail 4", n, 5);
        wr(5'h00, 0);
    endtask

    task automatic t_indep();
        int n, h;
        wr(5'h04, 2); wr(5'h0C, 2);
        wr(5'h08, 6); wr(5'h10, 1);
        wr(5'h00, 2);
        wait_sig(1, 100, n); check(n == 4, "R3 timer1 alone", n, 4);
        count_high(0, 20, h); check(h == 0, "R3 timer0 silent when bit0 clear", h, 0);
        wr(5'h00, 3);
        wait_sig(0, 100, n); check(n == 7, "R3 timer0 starts on bit0", n, 7);
        count_high(1, 40, h); check(h == 10, "R3 timer1 unaffected by bit0", h, 10);
        wr(5'h00, 0);
    endtask

    task automatic t_stop();
        int n, h;
        wr(5'h08, 4); wr(5'h10, 4);
        wr(5'h00, 1);
        repeat (5) @(negedge clk);
        wr(5'h00, 0);
        count_high(0, 30, h); check(h == 0, "R6 no irq after disable", h, 0);
        check(wdog_rst_req == 0, "R6 no reset request after disable", wdog_rst_req, 0);
        wr(5'h00, 1);
        wait_sig(0, 100, n); check(n == 8, "R6 fresh period after re-enable", n, 8);
        wr(5'h00, 0);
    endtask

    task automatic t_t1_magic();
        int n;
        wr(5'h04, 32'h0000_00FF); wr(5'h0C, 1);
        wr(5'h00, 2);
        wait_sig(1, 1000, n); check(n == 256, "R9 timer1 0xFF is plain count", n, 256);
        check(wdog_rst_req == 0, "R9 no reset request from timer1", wdog_rst_req, 0);
        wr(5'h00, 0);
    endtask

    task automatic t_watchdog();
        int n, h;
        wr(5'h08, (10 << 8) | 32'hFF); wr(5'h10, 3);
        wr(5'h00, 1);
        wait_sig(2, 100, n); check(n == 10, "R7 watchdog expiry cycle", n, 10);
        count_high(0, 20, h); check(h == 0, "R7 no irq0 in watchdog mode", h, 0);
        wr(5'h00, 0);
        count_high(2, 10, h); check(h == 10, "R8 request held after disable", h, 10);
        do_reset();
        check(wdog_rst_req == 0, "R8 request cleared by reset", wdog_rst_req, 0);
    endtask

    initial begin
        t_reset();
        t_regmap();
        t_period();
        t_zero();
        t_indep();
        t_stop();
        t_t1_magic();
        t_watchdog();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG_CYC) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule